// File: doc/BRIEF.md
# Shifted-Operand Subtract-With-Carry Execute Slice

This block is one execute-stage slice of a 32-bit processor datapath. It performs a single operation: subtract with carry. The second operand can first be shifted. Each cycle the block accepts three things along with a valid strobe:

- a 32-bit wide instruction word,
- the two register values the instruction names,
- the current condition flags.

The control part decodes the instruction word. It extracts the two source register indices, the destination index, the shift kind, the 5-bit shift amount and the flag-update bit. The two source indices are offered combinationally, so a register file can read from them.

The datapath shifts the second operand, then adds the first operand, the bitwise inverse of the shifted value and the incoming carry. That sum equals first − shifted − (1 − carry), so the carry flag means "no borrow". The result, the destination index and the new flags appear one clock later on registered outputs. When the flag-update bit is clear, the flag output carries the incoming flags unchanged.

Top module: `subc_shift_exec`

## Requirements
- R1: Instruction fields are decoded from these bit positions:
  - bit 20 is the flag-update bit S;
  - bits 19:16 are the first source index, shown at once on `srcAIdx`;
  - bits 3:0 are the second source index, shown at once on `srcBIdx`;
  - bits 11:8 are the destination index, registered to `destIdx`;
  - the shift amount is bits 14:12 (high part) concatenated with bits 7:6 (low part);
  - bits 5:4 select the shift kind.
- R2: The result equals `opA + ~shifted + C`, where C is `flagsIn[1]`. The flag vector layout, for both inputs and outputs, is bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V.
- R3: `outValid` is high in exactly the cycle after a cycle with `inValid` high. All other outputs are updated at that same edge.
- R4: When S is 1, flag N takes bit 31 of the result, and flag Z is 1 exactly when the result is zero.
- R5: When S is 1, flag C takes the carry out of the 33-bit addition (1 means no borrow), and flag V takes that addition's signed overflow.
- R6: When S is 0, `flagsWr` stays low and `flagsOut` equals the `flagsIn` value that was captured.
- R7: Shift kind 00 is a logical left shift by the amount. An amount of 0 leaves the operand unchanged.
- R8: Shift kinds 01 (logical right) and 10 (arithmetic right) treat an amount of 0 as a shift by 32. Logical right then yields 0, and arithmetic right yields 32 copies of bit 31.
- R9: Shift kind 11 with a nonzero amount rotates the operand right by that amount.
- R10: Shift kind 11 with an amount of 0 rotates right by one through carry: the incoming C flag enters at bit 31.
- R11: During reset, `outValid`, `flagsWr`, `result`, `destIdx` and `flagsOut` are all zero.
- R12: While `inValid` is low, `result`, `destIdx` and `flagsOut` keep their values and `flagsWr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Inputs carry an operation this cycle |
| instrWord | input | 32 | Raw wide instruction word |
| opA | input | 32 | Value of the first source register |
| opB | input | 32 | Value of the second source register, before the shift |
| flagsIn | input | 4 | Current N,Z,C,V flags |
| srcAIdx | output | 4 | First source index, combinational |
| srcBIdx | output | 4 | Second source index, combinational |
| outValid | output | 1 | Registered result is new this cycle |
| result | output | 32 | Registered difference |
| destIdx | output | 4 | Registered destination index |
| flagsOut | output | 4 | Registered N,Z,C,V after the operation |
| flagsWr | output | 1 | Flags were computed by this operation |

## Verification
The subtraction is tried with several patterns, each aimed at a different fault:
- 0 − 0 with carry clear. This must give all ones with no carry, which separates a correct inverted-carry term from a plain subtract.
- 0x80000000 − 1 with carry set. This must raise overflow, which separates true signed-overflow logic from a simple sign-bit test.
- Equal operands with carry set. This must give zero with the carry set, which confirms that the carry means "no borrow".

Each shift kind is run at amount 0 and at a nonzero amount. This shows the amount-0 special cases (no shift, shift by 32, and the rotate through an incoming carry of 0 and of 1) apart from the ordinary shifts. Flag-update-clear operations and idle cycles show that the incoming flags pass through and that the outputs hold.

// File: rtl/subc_pkg.sv
package subc_pkg;
  localparam int DATA_W  = 32;
  localparam int IDX_W   = 4;
  localparam int SHAMT_W = 5;
  localparam int FLAG_W  = 4;

  // flag vector bit positions
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shiftKind_e;

  typedef struct packed {
    logic               capture;
    logic               setFlags;
    shiftKind_e         kind;
    logic [SHAMT_W-1:0] amount;
    logic [IDX_W-1:0]   destIdx;
  } ctrlStrobes_t;
endpackage

// File: rtl/subc_ctrl.sv
module subc_ctrl
  import subc_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic               inValid,
  input  logic [INSTR_W-1:0] instrWord,
  output ctrlStrobes_t       strobes,
  output logic [IDX_W-1:0]   srcAIdx,
  output logic [IDX_W-1:0]   srcBIdx
);
  // field positions of the wide encoding
  localparam int S_POS   = 20;
  localparam int RA_LO   = 16;
  localparam int RD_LO   = 8;
  localparam int RB_LO   = 0;
  localparam int AMTH_LO = 12;
  localparam int AMTL_LO = 6;
  localparam int KIND_LO = 4;
  localparam int AMTL_W  = 2;
  localparam int AMTH_W  = SHAMT_W - AMTL_W;

  logic unusedOpBits;
  assign unusedOpBits = ^{instrWord[INSTR_W-1:S_POS+1], instrWord[AMTH_LO+AMTH_W]};

  assign srcAIdx = instrWord[RA_LO +: IDX_W];
  assign srcBIdx = instrWord[RB_LO +: IDX_W];

  always_comb begin
    strobes.capture  = inValid;
    strobes.setFlags = instrWord[S_POS];
    strobes.kind     = shiftKind_e'(instrWord[KIND_LO +: 2]);
    strobes.amount   = {instrWord[AMTH_LO +: AMTH_W], instrWord[AMTL_LO +: AMTL_W]};
    strobes.destIdx  = instrWord[RD_LO +: IDX_W];
  end
endmodule

// File: rtl/subc_shifter.sv
module subc_shifter
  import subc_pkg::*;
#(
  parameter int WIDTH = DATA_W,
  parameter int AMT_W = SHAMT_W
) (
  input  logic [WIDTH-1:0] opIn,
  input  shiftKind_e       kind,
  input  logic [AMT_W-1:0] amount,
  input  logic             carryIn,
  output logic [WIDTH-1:0] opOut
);
  localparam int DBL_W = 2 * WIDTH;

  logic             amtZero;
  logic [DBL_W-1:0] rotWide;

  assign amtZero = (amount == '0);
  assign rotWide = {opIn, opIn} >> amount;

  always_comb begin
    unique case (kind)
      SH_LSL: opOut = opIn << amount;
      SH_LSR: opOut = amtZero ? '0 : (opIn >> amount);
      SH_ASR: opOut = amtZero ? {WIDTH{opIn[WIDTH-1]}}
                              : WIDTH'($signed(opIn) >>> amount);
      SH_ROR: opOut = amtZero ? {carryIn, opIn[WIDTH-1:1]}
                              : rotWide[WIDTH-1:0];
      default: opOut = opIn;
    endcase
  end
endmodule

// File: rtl/subc_dpath.sv
module subc_dpath
  import subc_pkg::*;
#(
  parameter int WIDTH = DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic              outValid,
  output logic [WIDTH-1:0]  result,
  output logic [IDX_W-1:0]  destIdx,
  output logic [FLAG_W-1:0] flagsOut,
  output logic              flagsWr
);
  localparam int SUM_W = WIDTH + 1;

  logic              carryIn;
  logic [WIDTH-1:0]  shifted;
  logic [SUM_W-1:0]  sumFull;
  logic [WIDTH-1:0]  sumLow;
  logic [FLAG_W-1:0] newFlags;

  assign carryIn = flagsIn[FLAG_C];

  subc_shifter #(.WIDTH(WIDTH), .AMT_W(SHAMT_W)) i_shifter (
    .opIn   (opB),
    .kind   (strobes.kind),
    .amount (strobes.amount),
    .carryIn(carryIn),
    .opOut  (shifted)
  );

  // subtract as add of the inverted operand; carry out = no borrow
  assign sumFull = {1'b0, opA} + {1'b0, ~shifted} + {{WIDTH{1'b0}}, carryIn};
  assign sumLow  = sumFull[WIDTH-1:0];

  always_comb begin
    newFlags = flagsIn;
    if (strobes.setFlags) begin
      newFlags[FLAG_N] = sumLow[WIDTH-1];
      newFlags[FLAG_Z] = (sumLow == '0);
      newFlags[FLAG_C] = sumFull[WIDTH];
      newFlags[FLAG_V] = (opA[WIDTH-1] == ~shifted[WIDTH-1]) &&
                         (sumLow[WIDTH-1] != opA[WIDTH-1]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      flagsWr  <= 1'b0;
      result   <= '0;
      destIdx  <= '0;
      flagsOut <= '0;
    end else begin
      outValid <= strobes.capture;
      flagsWr  <= strobes.capture & strobes.setFlags;
      if (strobes.capture) begin
        result   <= sumLow;
        destIdx  <= strobes.destIdx;
        flagsOut <= newFlags;
      end
    end
  end
endmodule

// File: rtl/subc_shift_exec.sv
module subc_shift_exec
  import subc_pkg::*;
#(
  parameter int WIDTH   = DATA_W,
  parameter int INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  input  logic [FLAG_W-1:0]  flagsIn,
  output logic [IDX_W-1:0]   srcAIdx,
  output logic [IDX_W-1:0]   srcBIdx,
  output logic               outValid,
  output logic [WIDTH-1:0]   result,
  output logic [IDX_W-1:0]   destIdx,
  output logic [FLAG_W-1:0]  flagsOut,
  output logic               flagsWr
);
  ctrlStrobes_t strobes;

  subc_ctrl #(.INSTR_W(INSTR_W)) i_ctrl (
    .inValid  (inValid),
    .instrWord(instrWord),
    .strobes  (strobes),
    .srcAIdx  (srcAIdx),
    .srcBIdx  (srcBIdx)
  );

  subc_dpath #(.WIDTH(WIDTH)) i_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .flagsIn (flagsIn),
    .outValid(outValid),
    .result  (result),
    .destIdx (destIdx),
    .flagsOut(flagsOut),
    .flagsWr (flagsWr)
  );
endmodule

// File: rtl/subc_chk.sv
module subc_chk #(
  parameter int WIDTH   = 32,
  parameter int INSTR_W = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [INSTR_W-1:0] instrWord,
  input logic [WIDTH-1:0]   opA,
  input logic [WIDTH-1:0]   opB,
  input logic [3:0]         flagsIn,
  input logic               outValid,
  input logic [WIDTH-1:0]   result,
  input logic [3:0]         destIdx,
  input logic [3:0]         flagsOut,
  input logic               flagsWr
);
  // R3
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R3
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R6
  keep_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !flagsWr) |-> (flagsOut == $past(flagsIn)));

  // R6
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagsWr |-> (outValid && $past(instrWord[20])));

  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagsWr |-> (flagsOut[2] == (result == '0)));

  // R4
  neg_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagsWr |-> (flagsOut[3] == result[WIDTH-1]));

  // R2
  plain_sub_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && instrWord[14:12] == 3'b000 && instrWord[7:4] == 4'b0000) |=>
    (result == $past(opA) - $past(opB) - {{(WIDTH-1){1'b0}}, ~$past(flagsIn[1])}));

  // R12
  hold_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(result) && $stable(destIdx) && $stable(flagsOut) && !flagsWr));
endmodule

bind subc_shift_exec subc_chk #(.WIDTH(WIDTH), .INSTR_W(INSTR_W)) i_chk (.*);

// File: tb/test_subc_shift_exec.sv
module test_subc_shift_exec;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [3:0]  flagsIn = '0;
  logic [3:0]  srcAIdx, srcBIdx, destIdx, flagsOut;
  logic        outValid, flagsWr;
  logic [31:0] result;

  int compared = 0;
  int mismatched = 0;
  int cycleCnt = 0;

  always #10 clk = ~clk;

  subc_shift_exec i_subc_shift_exec (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instrWord(instrWord),
    .opA(opA), .opB(opB), .flagsIn(flagsIn), .srcAIdx(srcAIdx),
    .srcBIdx(srcBIdx), .outValid(outValid), .result(result),
    .destIdx(destIdx), .flagsOut(flagsOut), .flagsWr(flagsWr)
  );

  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt == 20000) begin
      mismatched++;
      $display("FAIL R3 watchdog expired: actual %0d cycles expected fewer", cycleCnt);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic cmp(input string tag, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [31:0] mkInstr(input bit s, input bit [3:0] ra, input bit [3:0] rd,
                                          input bit [3:0] rb, input bit [4:0] amt,
                                          input bit [1:0] kind);
    return 32'hEB60_0000 | (32'(s) << 20) | (32'(ra) << 16) | (32'(amt[4:2]) << 12) |
           (32'(rd) << 8) | (32'(amt[1:0]) << 6) | (32'(kind) << 4) | 32'(rb);
  endfunction

  function automatic logic [31:0] refShift(input logic [31:0] b, input bit [1:0] kind,
                                           input int amt, input bit c);
    logic [63:0] w;
    logic [31:0] r;
    case (kind)
      2'b00: begin w = {32'b0, b} << amt; r = w[31:0]; end
      2'b01: begin w = {b, 32'b0} >> ((amt == 0) ? 32 : amt); r = w[63:32]; end
      2'b10: begin w = {{32{b[31]}}, b} >> ((amt == 0) ? 32 : amt); r = w[31:0]; end
      default: begin
        r = b;
        if (amt == 0) r = {c, b[31:1]};
        else for (int i = 0; i < amt; i++) r = {r[0], r[31:1]};
      end
    endcase
    return r;
  endfunction

  task automatic runOp(input string tag, input bit s, input bit [3:0] ra, input bit [3:0] rd,
                       input bit [3:0] rb, input bit [4:0] amt, input bit [1:0] kind,
                       input logic [31:0] a, input logic [31:0] b, input logic [3:0] f);
    logic [31:0] sh, expRes;
    logic [3:0]  expF;
    longint      ua, us, sa, ss, ud, sd, bw;
    @(negedge clk);
    instrWord = mkInstr(s, ra, rd, rb, amt, kind);
    opA = a; opB = b; flagsIn = f; inValid = 1'b1;
    #1;
    cmp("R1", "srcAIdx", 32'(srcAIdx), 32'(ra));
    cmp("R1", "srcBIdx", 32'(srcBIdx), 32'(rb));
    sh = refShift(b, kind, int'(amt), f[1]);
    bw = f[1] ? 0 : 1;
    ua = longint'({32'b0, a}); us = longint'({32'b0, sh});
    sa = longint'($signed(a)); ss = longint'($signed(sh));
    ud = ua - us - bw;
    sd = sa - ss - bw;
    expRes = ud[31:0];
    expF = f;
    if (s) begin
      expF[3] = expRes[31];
      expF[2] = (expRes == 0);
      expF[1] = (ud >= 0);
      expF[0] = (sd > 64'sd2147483647) || (sd < -64'sd2147483648);
    end
    @(posedge clk);
    #2;
    cmp(tag, "result", result, expRes);
    cmp(tag, "flagsOut", 32'(flagsOut), 32'(expF));
    cmp(s ? "R4" : "R6", "flagsWr", 32'(flagsWr), 32'(s));
    cmp("R3", "outValid", 32'(outValid), 32'd1);
    cmp("R1", "destIdx", 32'(destIdx), 32'(rd));
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic testReset();
    #5;
    cmp("R11", "outValid", 32'(outValid), 0);
    cmp("R11", "flagsWr", 32'(flagsWr), 0);
    cmp("R11", "result", result, 0);
    cmp("R11", "destIdx", 32'(destIdx), 0);
    cmp("R11", "flagsOut", 32'(flagsOut), 0);
  endtask

  task automatic testCorners();
    runOp("R5", 1, 4'd1, 4'd0, 4'd2, 5'd0, 2'b00, 32'h0, 32'h0, 4'b0000);
    cmp("R5", "0-0 carry0 C", 32'(flagsOut[1]), 0);
    runOp("R5", 1, 4'd3, 4'd4, 4'd5, 5'd0, 2'b00, 32'h8000_0000, 32'h1, 4'b0010);
    cmp("R5", "signed overflow V", 32'(flagsOut[0]), 1);
    runOp("R4", 1, 4'd6, 4'd7, 4'd8, 5'd0, 2'b00, 32'h1234_5678, 32'h1234_5678, 4'b0010);
    cmp("R4", "equal Z", 32'(flagsOut[2]), 1);
    cmp("R5", "equal C", 32'(flagsOut[1]), 1);
    runOp("R2", 1, 4'd9, 4'd10, 4'd11, 5'd0, 2'b00, 32'h0000_0005, 32'h0000_0009, 4'b0010);
  endtask

  task automatic testShifts();
    runOp("R7", 1, 4'd1, 4'd2, 4'd3, 5'd4, 2'b00, 32'h0001_0000, 32'h0000_0F01, 4'b0010);
    runOp("R7", 1, 4'd1, 4'd2, 4'd3, 5'd31, 2'b00, 32'h0, 32'h3, 4'b0000);
    runOp("R8", 1, 4'd2, 4'd3, 4'd4, 5'd0, 2'b01, 32'h0000_0100, 32'hFFFF_FFFF, 4'b0000);
    runOp("R8", 1, 4'd2, 4'd3, 4'd4, 5'd3, 2'b01, 32'h0000_0100, 32'h8000_0000, 4'b0010);
    runOp("R8", 1, 4'd5, 4'd6, 4'd7, 5'd0, 2'b10, 32'h0000_0010, 32'h8000_0001, 4'b0010);
    runOp("R8", 1, 4'd5, 4'd6, 4'd7, 5'd0, 2'b10, 32'h0000_0010, 32'h7000_0001, 4'b0010);
    runOp("R8", 1, 4'd5, 4'd6, 4'd7, 5'd8, 2'b10, 32'h0, 32'h8100_0000, 4'b0010);
    runOp("R9", 1, 4'd8, 4'd9, 4'd10, 5'd8, 2'b11, 32'hFFFF_FFFF, 32'h1234_56AB, 4'b0010);
    runOp("R10", 1, 4'd11, 4'd12, 4'd13, 5'd0, 2'b11, 32'h0, 32'h0000_0003, 4'b0010);
    runOp("R10", 1, 4'd11, 4'd12, 4'd13, 5'd0, 2'b11, 32'h0, 32'h0000_0003, 4'b0000);
  endtask

  task automatic testNoFlags();
    runOp("R6", 0, 4'd14, 4'd15, 4'd0, 5'd0, 2'b00, 32'h0, 32'h0, 4'b1010);
    runOp("R6", 0, 4'd4, 4'd5, 4'd6, 5'd2, 2'b00, 32'h8000_0000, 32'h1, 4'b0101);
  endtask

  task automatic testHold();
    runOp("R12", 1, 4'd2, 4'd9, 4'd3, 5'd0, 2'b00, 32'h0000_0040, 32'h0000_0001, 4'b0010);
    // inputs change while idle; outputs must not follow
    instrWord = mkInstr(1'b1, 4'd1, 4'd3, 4'd1, 5'd0, 2'b00);
    opA = 32'hDEAD_BEEF; opB = 32'h1; flagsIn = 4'b1111;
    @(posedge clk);
    #2;
    cmp("R3", "outValid idle", 32'(outValid), 0);
    cmp("R12", "result held", result, 32'h0000_003F);
    cmp("R12", "destIdx held", 32'(destIdx), 9);
    cmp("R12", "flagsOut held", 32'(flagsOut), 32'(4'b0010));
    cmp("R12", "flagsWr idle", 32'(flagsWr), 0);
  endtask

  initial begin
    testReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testCorners();
    testShifts();
    testNoFlags();
    testHold();
    repeat (2) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule